// File: doc/BRIEF.md
# Nucleotide Codon Stream Encoder

The block turns one binary word into a stream of three-letter codons. In cipher mode the word is read two bits at a time, most significant pair first. Each pair becomes one nucleotide letter, and every three letters form one codon. In key mode the word first passes through a conditioning step and is then read the same way. The conditioning step works on the word's two halves. When a half has an odd number of bits, it gets one extra bit at its least significant end: 0 for the upper half and 1 for the lower half. The halves are joined again, upper half first, and the result is XORed with a dummy key of the same width.

Each codon goes out on a valid/ready stream and carries three things: its 6-bit base code, its three letters in messenger form as ASCII text, and an amino-acid index from the standard genetic code. If the last codon of a word has fewer than three real letters, it is filled out with A. The final codon of each word is flagged with `last`. A single state machine controls the stream. In SEQ_IDLE it accepts `start`. It moves to SEQ_EMIT when the word needs two or more codons, or straight to SEQ_FINAL when it needs only one. SEQ_EMIT steps to the next codon on each handshake and moves to SEQ_FINAL when one codon is left. SEQ_FINAL returns to SEQ_IDLE when its codon is taken.

Top module: `codon_stream_encoder`

## Requirements
- R1: Each 2-bit pair maps to one nucleotide (00=A, 01=C, 10=G, 11=T/U). Nucleotides are taken most significant pair first. Within `cod_bases`, bits [5:4] hold the first nucleotide of the codon and bits [1:0] the third.
- R2: `cod_text` gives the codon as three ASCII letters, first nucleotide in bits [23:16]. Pair 11 is always written as `U`, never `T`. A, C and G are written as themselves.
- R3: A cipher word of WORD_W bits produces ceil(WORD_W/6) codons. Each codon holds three consecutive nucleotides.
- R4: If the final codon has fewer than three real nucleotides, the missing positions are filled with A (00).
- R5: In key mode, a half of odd length is extended at its least significant end, with 0 for the upper half and 1 for the lower half. The halves are then joined upper first. This makes KEY_W bits.
- R6: In key mode, the conditioned key is XORed with `dummy_key` before it is split into nucleotides.
- R7: `cod_amino` gives the amino acid's rank in alphabetical one-letter order (A=0, C=1, ... Y=19). The stop codons UAA, UAG and UGA give 31.
- R8: While `cod_valid` is high and `cod_ready` is low, `cod_valid`, `cod_bases`, `cod_text`, `cod_amino` and `cod_last` hold their values.
- R9: `cod_last` is high only on the final codon of a word. `cod_valid` is low in the cycle after that codon is accepted.
- R10: `start` is ignored while a word is being emitted.
- R11: After reset `cod_valid` is low.
- R12: The first codon is valid in the cycle after `start` is sampled in SEQ_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a word; sampled only when idle |
| sel_key | input | 1 | 1 = key mode, 0 = cipher mode |
| word_in | input | WORD_W | Word to encode |
| dummy_key | input | KEY_W | Dummy key XORed in key mode |
| cod_valid | output | 1 | Codon available |
| cod_ready | input | 1 | Consumer accepts the codon |
| cod_last | output | 1 | Final codon of the word |
| cod_bases | output | 6 | Three 2-bit nucleotide codes |
| cod_text | output | 24 | Three ASCII letters, messenger form |
| cod_amino | output | 5 | Amino-acid index, 31 = stop |

## Verification
Some properties are checked on every cycle: the stall hold, `valid` dropping after an accepted last codon, `start` having no effect on a busy shift register, `last` falling only on the closing count, uracil labelling and stop-codon indexing. Other behaviour can only be shown by the bench's scenarios against a separately computed model. That covers bit order, codon grouping, A-filled tails, half padding in key mode, the XOR with the dummy key, the full amino table and the absence of extra codons after an ignored start.

// File: rtl/codon_pkg.sv
package codon_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_EMIT  = 2'd1,
        SEQ_FINAL = 2'd2
    } seq_state_t;

    localparam logic [4:0] AMINO_STOP = 5'd31;

    // alphabetical one-letter rank of each amino acid
    localparam logic [4:0] AA_A = 5'd0,  AA_C = 5'd1,  AA_D = 5'd2,  AA_E = 5'd3;
    localparam logic [4:0] AA_F = 5'd4,  AA_G = 5'd5,  AA_H = 5'd6,  AA_I = 5'd7;
    localparam logic [4:0] AA_K = 5'd8,  AA_L = 5'd9,  AA_M = 5'd10, AA_N = 5'd11;
    localparam logic [4:0] AA_P = 5'd12, AA_Q = 5'd13, AA_R = 5'd14, AA_S = 5'd15;
    localparam logic [4:0] AA_T = 5'd16, AA_V = 5'd17, AA_W = 5'd18, AA_Y = 5'd19;

    // messenger-form letter of one nucleotide (11 shown as uracil)
    function automatic logic [7:0] nt_letter(input logic [1:0] nt);
        unique case (nt)
            2'b00:   nt_letter = 8'h41;
            2'b01:   nt_letter = 8'h43;
            2'b10:   nt_letter = 8'h47;
            default: nt_letter = 8'h55;
        endcase
    endfunction

    // genetic code; third base pyrimidine (C/U) has bit 0 set
    function automatic logic [4:0] amino_of(input logic [5:0] b);
        logic pyr;
        pyr = b[0];
        unique case (b[5:2])
            4'b0000: amino_of = pyr ? AA_N : AA_K;                         // AA.
            4'b0001: amino_of = AA_T;                                      // AC.
            4'b0010: amino_of = pyr ? AA_S : AA_R;                         // AG.
            4'b0011: amino_of = (b[1:0] == 2'b10) ? AA_M : AA_I;           // AU.
            4'b0100: amino_of = pyr ? AA_H : AA_Q;                         // CA.
            4'b0101: amino_of = AA_P;                                      // CC.
            4'b0110: amino_of = AA_R;                                      // CG.
            4'b0111: amino_of = AA_L;                                      // CU.
            4'b1000: amino_of = pyr ? AA_D : AA_E;                         // GA.
            4'b1001: amino_of = AA_A;                                      // GC.
            4'b1010: amino_of = AA_G;                                      // GG.
            4'b1011: amino_of = AA_V;                                      // GU.
            4'b1100: amino_of = pyr ? AA_Y : AMINO_STOP;                   // UA.
            4'b1101: amino_of = AA_S;                                      // UC.
            4'b1110: amino_of = pyr ? AA_C :
                                ((b[1:0] == 2'b10) ? AA_W : AMINO_STOP);   // UG.
            default: amino_of = pyr ? AA_F : AA_L;                         // UU.
        endcase
    endfunction

endpackage

// File: rtl/codon_key_cond.sv
module codon_key_cond #(
    parameter int WORD_W = 64,
    localparam int HALF  = WORD_W / 2,
    localparam int KEY_W = (HALF % 2 == 1) ? WORD_W + 2 : WORD_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [KEY_W-1:0]  dummy_key,
    output logic [KEY_W-1:0]  key_out
);

    logic [KEY_W-1:0] padded;

    generate
        if (HALF % 2 == 1) begin : g_odd_half
            assign padded = {word_in[WORD_W-1:HALF], 1'b0, word_in[HALF-1:0], 1'b1};
        end else begin : g_even_half
            assign padded = word_in;
        end
    endgenerate

    assign key_out = padded ^ dummy_key;

endmodule

// File: rtl/codon_lut.sv
module codon_lut
    import codon_pkg::*;
(
    input  logic [5:0]  bases,
    output logic [23:0] text,
    output logic [4:0]  amino
);

    generate
        for (genvar p = 0; p < 3; p++) begin : g_letter
            assign text[8*p +: 8] = nt_letter(bases[2*p +: 2]);
        end
    endgenerate

    assign amino = amino_of(bases);

endmodule

// File: rtl/codon_seq.sv
module codon_seq
    import codon_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int KEY_W  = 64,
    localparam int COD_CIPH = (WORD_W / 2 + 2) / 3,
    localparam int COD_KEY  = (KEY_W / 2 + 2) / 3,
    localparam int COD_MAX  = (COD_CIPH > COD_KEY) ? COD_CIPH : COD_KEY,
    localparam int SR_W     = COD_MAX * 6,
    localparam int CNT_W    = $clog2(COD_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sel_key,
    input  logic [WORD_W-1:0] cipher_word,
    input  logic [KEY_W-1:0]  key_word,
    input  logic              ready,
    output logic              valid,
    output logic              last,
    output logic [5:0]        head
);

    localparam int SH_C = SR_W - WORD_W;
    localparam int SH_K = SR_W - KEY_W;

    seq_state_t       state_q, state_d;
    logic [SR_W-1:0]  sr_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_cnt;
    logic [SR_W-1:0]  load_val;

    // words are MSB-aligned; zero fill below supplies the A tail padding
    assign load_cnt = sel_key ? CNT_W'(COD_KEY) : CNT_W'(COD_CIPH);
    assign load_val = sel_key ? (SR_W'(key_word) << SH_K)
                              : (SR_W'(cipher_word) << SH_C);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = (load_cnt == CNT_W'(1)) ? SEQ_FINAL : SEQ_EMIT;
            SEQ_EMIT:  if (ready) state_d = (remain_q == CNT_W'(2)) ? SEQ_FINAL : SEQ_EMIT;
            SEQ_FINAL: if (ready) state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // shift register and codon counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= '0;
            remain_q <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (start) begin
                sr_q     <= load_val;
                remain_q <= load_cnt;
            end
        end else if (ready) begin
            sr_q     <= sr_q << 6;
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        valid = 1'b0;
        last  = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  ;
            SEQ_EMIT:  valid = 1'b1;
            SEQ_FINAL: begin valid = 1'b1; last = 1'b1; end
            default:   ;
        endcase
        head = sr_q[SR_W-1 -: 6];
    end

    // R8: stalled codon is held
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(head) && $stable(last)));

    // R9: stream goes quiet after the last codon is taken
    assert_drop_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> !valid);

    // R10: start while busy leaves the loaded word alone
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SEQ_IDLE && start && !ready) |=> $stable(sr_q));

    // R3: the final codon coincides with one remaining count
    assert_final_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_FINAL) |-> (remain_q == CNT_W'(1)));

endmodule

// File: rtl/codon_stream_encoder.sv
module codon_stream_encoder
    import codon_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int HALF  = WORD_W / 2,
    localparam int KEY_W = (HALF % 2 == 1) ? WORD_W + 2 : WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sel_key,
    input  logic [WORD_W-1:0] word_in,
    input  logic [KEY_W-1:0]  dummy_key,
    output logic              cod_valid,
    input  logic              cod_ready,
    output logic              cod_last,
    output logic [5:0]        cod_bases,
    output logic [23:0]       cod_text,
    output logic [4:0]        cod_amino
);

    logic [KEY_W-1:0] key_word;

    codon_key_cond #(.WORD_W(WORD_W)) u_key (
        .word_in   (word_in),
        .dummy_key (dummy_key),
        .key_out   (key_word)
    );

    codon_seq #(.WORD_W(WORD_W), .KEY_W(KEY_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sel_key     (sel_key),
        .cipher_word (word_in),
        .key_word    (key_word),
        .ready       (cod_ready),
        .valid       (cod_valid),
        .last        (cod_last),
        .head        (cod_bases)
    );

    codon_lut u_lut (
        .bases (cod_bases),
        .text  (cod_text),
        .amino (cod_amino)
    );

    // R2: pair 11 is labelled uracil
    assert_uracil_label_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cod_valid && cod_bases[1:0] == 2'b11) |-> (cod_text[7:0] == 8'h55));

    // R7: stop index only for UAA, UAG, UGA
    assert_stop_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cod_valid && cod_amino == AMINO_STOP) |->
        (cod_bases == 6'b110000 || cod_bases == 6'b110010 || cod_bases == 6'b111000));

    // R9: last only with valid
    assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cod_last |-> cod_valid);

endmodule

// File: tb/codon_stream_encoder_bench.sv
`timescale 1ns/1ps
module codon_stream_encoder_bench;

    localparam int W  = 22;
    localparam int KW = 24;

    typedef struct {
        logic [5:0]  b;
        logic [23:0] tx;
        logic [4:0]  am;
        logic        last;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sel_key = 1'b0;
    logic [W-1:0]  word_in = '0;
    logic [KW-1:0] dummy_key = '0;
    logic          cod_ready = 1'b0;
    logic          cod_valid, cod_last;
    logic [5:0]    cod_bases;
    logic [23:0]   cod_text;
    logic [4:0]    cod_amino;

    int   checks = 0;
    int   fails  = 0;
    int   ready_mode = 0;     // 0 always, 1 pseudo-random, 2 held low
    logic [7:0] lfsr = 8'hA5;
    string cur_tag = "R1";
    exp_t  sb[$];
    bit    done = 1'b0;

    always #2 clk = ~clk;

    codon_stream_encoder #(.WORD_W(W)) u_codon_stream_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_key(sel_key),
        .word_in(word_in), .dummy_key(dummy_key),
        .cod_valid(cod_valid), .cod_ready(cod_ready), .cod_last(cod_last),
        .cod_bases(cod_bases), .cod_text(cod_text), .cod_amino(cod_amino)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] model_amino(input logic [5:0] b);
        string tbl, abc;
        byte   ch;
        tbl = "KNKNTTTTRSRSIIMIQHQHPPPPRRRRLLLLEDEDAAAAGGGGVVVV*Y*YSSSS*CWCLFLF";
        abc = "ACDEFGHIKLMNPQRSTVWY";
        ch  = tbl[int'(b)];
        model_amino = 5'd31;
        for (int i = 0; i < 20; i++) if (abc[i] == ch) model_amino = 5'(i);
    endfunction

    function automatic logic [7:0] model_letter(input logic [1:0] n);
        string s;
        s = "ACGU";
        model_letter = s[int'(n)];
    endfunction

    // scoreboard driver: compute expected codons, then pulse start
    task automatic send(input bit key, input logic [W-1:0] w, input logic [KW-1:0] d);
        logic [KW-1:0] v;
        int nt, ncod;
        exp_t e;
        if (key) begin
            v  = {w[21:11], 1'b0, w[10:0], 1'b1} ^ d;
            nt = 12;
        end else begin
            v  = {w, 2'b00};
            nt = 11;
        end
        ncod = (nt + 2) / 3;
        for (int c = 0; c < ncod; c++) begin
            e.b    = v[KW-1-6*c -: 6];
            e.tx   = {model_letter(e.b[5:4]), model_letter(e.b[3:2]), model_letter(e.b[1:0])};
            e.am   = model_amino(e.b);
            e.last = (c == ncod - 1);
            sb.push_back(e);
        end
        sel_key = key; word_in = w; dummy_key = d; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((sb.size() != 0 || cod_valid) && n < 500) begin
            @(posedge clk); #1;
            n++;
        end
        check(n < 500, cur_tag, "drain", 32'(sb.size()), 0);
        @(negedge clk);
        check(!cod_valid, "R9", "valid after last", 32'(cod_valid), 0);
    endtask

    // ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cod_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
        end
    end

    // monitor
    initial begin
        bit         stalled = 0;
        logic [5:0] pb = '0;
        logic [23:0] pt = '0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (stalled) begin
                    check(cod_valid && cod_bases == pb && cod_text == pt, "R8",
                          "stall hold", 32'(cod_bases), 32'(pb));
                end
                stalled = cod_valid && !cod_ready;
                pb = cod_bases; pt = cod_text;
                if (cod_valid && cod_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R10", "unexpected codon", 32'(cod_bases), 0);
                    end else begin
                        e = sb.pop_front();
                        check(cod_bases == e.b, cur_tag, "bases", 32'(cod_bases), 32'(e.b));
                        check(cod_text == e.tx, "R2", "text", 32'(cod_text), 32'(e.tx));
                        check(cod_amino == e.am, "R7", "amino", 32'(cod_amino), 32'(e.am));
                        check(cod_last == e.last, "R9", "last", 32'(cod_last), 32'(e.last));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        check(!cod_valid, "R11", "reset valid", 32'(cod_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 R12: cipher word, latency of one cycle
        cur_tag = "R1";
        send(1'b0, 22'h2A5F3C, '0);
        @(negedge clk);
        check(cod_valid, "R12", "first codon latency", 32'(cod_valid), 1);
        drain();

        // R3 R4: tail padding; word with stop codons and uracils
        cur_tag = "R4";
        send(1'b0, 22'b1100001110001111111111, '0);
        drain();

        // R5: odd halves padded, dummy zero
        cur_tag = "R5";
        send(1'b1, 22'h3FFFFF, '0);
        drain();
        send(1'b1, 22'h000000, '0);
        drain();

        // R6: dummy key XOR with random stalls
        cur_tag = "R6";
        ready_mode = 1;
        send(1'b1, 22'h15A3C7, 24'hC3A55A);
        drain();
        send(1'b1, 22'h2B01F0, 24'hFFFFFF);
        drain();

        // R3: cipher words under stalls, back to back
        cur_tag = "R3";
        for (int k = 0; k < 6; k++) begin
            send(1'b0, 22'(32'h9E3779B9 * (k + 1)), '0);
            drain();
        end

        // R10: start while busy is ignored
        cur_tag = "R10";
        ready_mode = 2;
        send(1'b0, 22'h123456, '0);
        repeat (2) @(posedge clk); #1;
        sel_key = 1'b1; word_in = 22'h3C3C3C; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (2) @(posedge clk); #1;
        ready_mode = 0;
        drain();
        repeat (10) @(posedge clk); #1;
        check(sb.size() == 0 && !cod_valid, "R10", "no extra word",
              32'(cod_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule